// File: doc/BRIEF.md
# Read-to-Clear Interrupt Status Unit

This unit holds the interrupt state of a two-wire serial bus controller. Event pulses from the bus engine and the FIFOs set sticky status bits that software clears. Two level bits follow FIFO fill conditions and drop only when those conditions go away. A transmit-abort event also records its cause bits in an abort-source register. The same event raises a flush-hold output that keeps the transmit FIFO locked.

Software clears state by reading. Each clear address returns the current state of its flag in bit 0 and clears that flag as a side effect of the read. A group clear address wipes every software-clearable bit and the abort-source register at once. One abort cause bit is protected: it survives clearing reads while its cause input is still active. A writable mask selects which raw bits drive the combined interrupt output.

Top module: `rclr_intr_unit`

## Requirements
- R1: A read returns 16 bits, registered one cycle after `rd_en`. At a clear address, bit 0 is the flag state before the read and bits 15:1 are zero. A read at any other address returns 0 and changes no state.
- R2: After a synchronous reset, `raw_stat`, `abrt_src`, `irq_out`, `flush_hold`, `rd_data` and the mask are all zero.
- R3: Raw bits 2 and 4 are level bits. In the cycle after `lvl_in[2]` or `lvl_in[4]` changes, the matching raw bit takes the new value. No clear read affects these bits. `ev_set` is ignored at level positions, and `lvl_in` is ignored at every other position.
- R4: A one-cycle pulse on `ev_set[i]`, for i in {0,1,3,5,6,7}, sets raw bit i. The bit stays set until it is cleared. `abort_valid` also sets raw bit 6.
- R5: The following reads each clear exactly one raw bit:
  - 0x44 clears bit 0 (receive underflow).
  - 0x48 clears bit 1 (receive overflow).
  - 0x4C clears bit 3 (transmit overflow).
  - 0x50 clears bit 5 (read request).
- R6: A read at 0x40 returns the combined interrupt in bit 0. It clears all software-clearable raw bits (0,1,3,5,6,7) and the abort-source register, subject to R8.
- R7: A read at 0x54 returns raw bit 6. It clears raw bit 6 and the abort-source register, subject to R8, and it releases `flush_hold`.
- R8: Abort-source bit 9 is not cleared by a read at 0x40 or 0x54 while `hold_cond` is high. When `hold_cond` is low, those reads clear it.
- R9: When a set (an `ev_set` pulse or `abort_valid`) lands in the same cycle as a read that clears the same bit, the bit ends up set. The same rule holds for `flush_hold`.
- R10: `irq_out` is the OR of (raw & mask), updated in the same cycle as `raw_stat`. A write with `mask_we` loads `mask_wdata`.
- R11: `flush_hold` rises in the cycle after `abort_valid` and stays high until the cycle after a read at 0x40 or 0x54.
- R12: When `abort_valid` is high, the bits of `abort_cause` are ORed into `abrt_src`, and `abrt_src` keeps them until they are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_set | input | 8 | Set pulses for the sticky raw bits |
| lvl_in | input | 8 | Level conditions; only bits 2 and 4 are used |
| abort_valid | input | 1 | Transmit abort event pulse |
| abort_cause | input | 16 | Abort cause bits, captured with `abort_valid` |
| hold_cond | input | 1 | Active cause behind abort-source bit 9 |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 8 | New mask value |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 16 | Registered read data |
| raw_stat | output | 8 | Raw interrupt bits |
| abrt_src | output | 16 | Abort-source register |
| irq_out | output | 1 | Combined masked interrupt |
| flush_hold | output | 1 | Transmit FIFO lock after an abort |

## Verification
A set pulse and a clearing read can land on the same bit in the same cycle. The bench provokes this twice:
- It raises `ev_set[0]` together with a read at 0x44.
- It raises `abort_valid` together with a read at 0x54.

In both cases it expects the bit to read back set one cycle later. In the abort case it also expects `flush_hold` to stay high. A second clearing read with no pulse must then bring both down, which shows that the earlier read really took effect.

// File: rtl/rclr_pkg.sv
package rclr_pkg;
  localparam int ADDR_CLR_ALL = 'h40;
  localparam int ADDR_CLR_RXU = 'h44;
  localparam int ADDR_CLR_RXO = 'h48;
  localparam int ADDR_CLR_TXO = 'h4C;
  localparam int ADDR_CLR_RDQ = 'h50;
  localparam int ADDR_CLR_ABT = 'h54;

  localparam int BIT_RXU = 0;
  localparam int BIT_RXO = 1;
  localparam int BIT_TXO = 3;
  localparam int BIT_RDQ = 5;
  localparam int BIT_ABT = 6;
endpackage

// File: rtl/rclr_raw_bank.sv
module rclr_raw_bank #(
  parameter int RAW_W = 8,
  parameter logic [RAW_W-1:0] LEVEL_MASK = 'h14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [RAW_W-1:0] ev_set,
  input  logic [RAW_W-1:0] lvl_in,
  input  logic [RAW_W-1:0] clr_vec,
  input  logic             mask_we,
  input  logic [RAW_W-1:0] mask_wdata,
  output logic [RAW_W-1:0] raw_q,
  output logic             irq_q
);
  logic [RAW_W-1:0] raw_d;
  logic [RAW_W-1:0] mask_q;
  logic [RAW_W-1:0] mask_d;

  for (genvar i = 0; i < RAW_W; i++) begin : g_bit
    if (LEVEL_MASK[i]) begin : g_lvl
      assign raw_d[i] = lvl_in[i];
      // level bits track their condition, clears have no say (R3)
      a_r3_level_high: assert property (@(posedge clk) disable iff (rst)
        lvl_in[i] |=> raw_q[i]);
      a_r3_level_low: assert property (@(posedge clk) disable iff (rst)
        !lvl_in[i] |=> !raw_q[i]);
    end else begin : g_sw
      assign raw_d[i] = ev_set[i] | (raw_q[i] & ~clr_vec[i]);
      a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        ev_set[i] |=> raw_q[i]);
      a_r5_clear_takes: assert property (@(posedge clk) disable iff (rst)
        (clr_vec[i] && !ev_set[i]) |=> !raw_q[i]);
    end
  end

  assign mask_d = mask_we ? mask_wdata : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
      irq_q  <= |(raw_d & mask_d);
    end
  end

  a_r10_irq_match: assert property (@(posedge clk) disable iff (rst)
    irq_q == |(raw_q & mask_q));
endmodule

// File: rtl/rclr_abort.sv
module rclr_abort #(
  parameter int ABRT_W   = 16,
  parameter int HOLD_BIT = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort_valid,
  input  logic [ABRT_W-1:0] abort_cause,
  input  logic              hold_cond,
  input  logic              clr_abrt,
  output logic [ABRT_W-1:0] src_q,
  output logic              flush_q
);
  logic [ABRT_W-1:0] cause_in;
  logic [ABRT_W-1:0] src_d;

  assign cause_in = abort_valid ? abort_cause : '0;

  for (genvar i = 0; i < ABRT_W; i++) begin : g_src
    if (i == HOLD_BIT) begin : g_hold
      assign src_d[i] = cause_in[i] | (src_q[i] & ~(clr_abrt & ~hold_cond));
    end else begin : g_plain
      assign src_d[i] = cause_in[i] | (src_q[i] & ~clr_abrt);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q   <= '0;
      flush_q <= 1'b0;
    end else begin
      src_q   <= src_d;
      flush_q <= abort_valid | (flush_q & ~clr_abrt);
    end
  end

  a_r8_hold_survives: assert property (@(posedge clk) disable iff (rst)
    (src_q[HOLD_BIT] && hold_cond) |=> src_q[HOLD_BIT]);
  a_r11_flush_rises: assert property (@(posedge clk) disable iff (rst)
    abort_valid |=> flush_q);
  a_r7_flush_release: assert property (@(posedge clk) disable iff (rst)
    (clr_abrt && !abort_valid) |=> !flush_q);
  a_r12_cause_kept: assert property (@(posedge clk) disable iff (rst)
    (!clr_abrt) |=> ((src_q & $past(src_q)) == $past(src_q)));
endmodule

// File: rtl/rclr_decode.sv
module rclr_decode
  import rclr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int RAW_W  = 8,
  parameter logic [RAW_W-1:0] LEVEL_MASK = 'h14
) (
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [RAW_W-1:0]  raw_q,
  input  logic              irq_q,
  output logic [RAW_W-1:0]  clr_vec,
  output logic              clr_abrt,
  output logic              rd_bit
);
  logic [RAW_W-1:0] sel;
  logic             hit_all;
  logic             hit_abt;

  always_comb begin
    sel     = '0;
    hit_all = 1'b0;
    hit_abt = 1'b0;
    if (rd_addr == ADDR_W'(ADDR_CLR_ALL)) hit_all = 1'b1;
    else if (rd_addr == ADDR_W'(ADDR_CLR_RXU)) sel[BIT_RXU] = 1'b1;
    else if (rd_addr == ADDR_W'(ADDR_CLR_RXO)) sel[BIT_RXO] = 1'b1;
    else if (rd_addr == ADDR_W'(ADDR_CLR_TXO)) sel[BIT_TXO] = 1'b1;
    else if (rd_addr == ADDR_W'(ADDR_CLR_RDQ)) sel[BIT_RDQ] = 1'b1;
    else if (rd_addr == ADDR_W'(ADDR_CLR_ABT)) begin
      sel[BIT_ABT] = 1'b1;
      hit_abt      = 1'b1;
    end
  end

  assign clr_vec  = rd_en ? (hit_all ? ~LEVEL_MASK : sel) : '0;
  assign clr_abrt = rd_en & (hit_all | hit_abt);
  assign rd_bit   = hit_all ? irq_q : |(raw_q & sel);
endmodule

// File: rtl/rclr_intr_unit.sv
module rclr_intr_unit
  import rclr_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int RAW_W    = 8,
  parameter int ABRT_W   = 16,
  parameter int HOLD_BIT = 9,
  parameter logic [RAW_W-1:0] LEVEL_MASK = 'h14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RAW_W-1:0]  ev_set,
  input  logic [RAW_W-1:0]  lvl_in,
  input  logic              abort_valid,
  input  logic [ABRT_W-1:0] abort_cause,
  input  logic              hold_cond,
  input  logic              mask_we,
  input  logic [RAW_W-1:0]  mask_wdata,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [RAW_W-1:0]  raw_stat,
  output logic [ABRT_W-1:0] abrt_src,
  output logic              irq_out,
  output logic              flush_hold
);
  localparam logic [RAW_W-1:0] SW_MASK = ~LEVEL_MASK;

  logic [RAW_W-1:0] ev_all;
  logic [RAW_W-1:0] clr_vec;
  logic             clr_abrt;
  logic             rd_bit;
  logic             unused_inputs;

  assign unused_inputs = &{1'b0, ev_set & LEVEL_MASK, lvl_in & SW_MASK};

  always_comb begin
    ev_all          = ev_set & SW_MASK;
    ev_all[BIT_ABT] = ev_all[BIT_ABT] | abort_valid;
  end

  rclr_decode #(.ADDR_W(ADDR_W), .RAW_W(RAW_W), .LEVEL_MASK(LEVEL_MASK)) u_decode (
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .raw_q   (raw_stat),
    .irq_q   (irq_out),
    .clr_vec (clr_vec),
    .clr_abrt(clr_abrt),
    .rd_bit  (rd_bit)
  );

  rclr_raw_bank #(.RAW_W(RAW_W), .LEVEL_MASK(LEVEL_MASK)) u_raw (
    .clk       (clk),
    .rst       (rst),
    .ev_set    (ev_all),
    .lvl_in    (lvl_in),
    .clr_vec   (clr_vec),
    .mask_we   (mask_we),
    .mask_wdata(mask_wdata),
    .raw_q     (raw_stat),
    .irq_q     (irq_out)
  );

  rclr_abort #(.ABRT_W(ABRT_W), .HOLD_BIT(HOLD_BIT)) u_abort (
    .clk        (clk),
    .rst        (rst),
    .abort_valid(abort_valid),
    .abort_cause(abort_cause),
    .hold_cond  (hold_cond),
    .clr_abrt   (clr_abrt),
    .src_q      (abrt_src),
    .flush_q    (flush_hold)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_en ? DATA_W'(rd_bit) : '0;
  end

  // group clear empties every sticky bit unless a pulse arrives (R6)
  a_r6_group_clear: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == ADDR_W'(ADDR_CLR_ALL) && ev_set == '0 && !abort_valid)
      |=> ((raw_stat & SW_MASK) == '0));
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rd_data == '0));
endmodule

// File: tb/rclr_intr_unit_bench.sv
`timescale 1ns/1ps
module rclr_intr_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  ev_set = '0;
  logic [7:0]  lvl_in = '0;
  logic        abort_valid = 1'b0;
  logic [15:0] abort_cause = '0;
  logic        hold_cond = 1'b0;
  logic        mask_we = 1'b0;
  logic [7:0]  mask_wdata = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [7:0]  raw_stat;
  logic [15:0] abrt_src;
  logic        irq_out;
  logic        flush_hold;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rclr_intr_unit u_rclr_intr_unit (
    .clk(clk), .rst(rst), .ev_set(ev_set), .lvl_in(lvl_in),
    .abort_valid(abort_valid), .abort_cause(abort_cause), .hold_cond(hold_cond),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .raw_stat(raw_stat), .abrt_src(abrt_src),
    .irq_out(irq_out), .flush_hold(flush_hold)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one read cycle; returns registered data
  task automatic do_read(input logic [7:0] a, output logic [15:0] d);
    rd_en = 1'b1; rd_addr = a;
    step();
    d = rd_data;
    rd_en = 1'b0; rd_addr = '0;
  endtask

  task automatic pulse_ev(input logic [7:0] v);
    ev_set = v;
    step();
    ev_set = '0;
  endtask

  task automatic t_reset();
    chk("R2 raw", 32'(raw_stat), 0);
    chk("R2 abrt", 32'(abrt_src), 0);
    chk("R2 irq", 32'(irq_out), 0);
    chk("R2 flush", 32'(flush_hold), 0);
    chk("R2 rd_data", 32'(rd_data), 0);
  endtask

  task automatic t_levels();
    logic [15:0] d;
    lvl_in = 8'hFF; step();
    chk("R3 level set", 32'(raw_stat), 32'h14);
    do_read(8'h40, d);
    chk("R3 level kept over group clear", 32'(raw_stat), 32'h14);
    pulse_ev(8'h14);
    lvl_in = 8'h00; step();
    chk("R3 level drop, ev ignored", 32'(raw_stat), 0);
  endtask

  task automatic t_single_clears();
    logic [15:0] d;
    pulse_ev(8'h2B);
    chk("R4 sticky set", 32'(raw_stat), 32'h2B);
    step();
    chk("R4 sticky hold", 32'(raw_stat), 32'h2B);
    do_read(8'h44, d);
    chk("R1 rd bit0", 32'(d), 1);
    chk("R5 clr rx under", 32'(raw_stat), 32'h2A);
    do_read(8'h48, d);
    chk("R5 clr rx over", 32'(raw_stat), 32'h28);
    do_read(8'h4C, d);
    chk("R5 clr tx over", 32'(raw_stat), 32'h20);
    do_read(8'h50, d);
    chk("R5 clr rd req", 32'(raw_stat), 0);
    do_read(8'h50, d);
    chk("R1 rd of cleared flag", 32'(d), 0);
  endtask

  task automatic t_unmapped();
    logic [15:0] d;
    pulse_ev(8'h01);
    do_read(8'h46, d);
    chk("R1 unmapped data", 32'(d), 0);
    chk("R1 unmapped no effect", 32'(raw_stat), 1);
    do_read(8'h44, d);
    chk("R1 cleanup", 32'(raw_stat), 0);
  endtask

  task automatic t_mask_group();
    logic [15:0] d;
    pulse_ev(8'h83);
    chk("R10 masked off", 32'(irq_out), 0);
    mask_we = 1'b1; mask_wdata = 8'h02; step(); mask_we = 1'b0;
    chk("R10 mask on", 32'(irq_out), 1);
    do_read(8'h40, d);
    chk("R6 group returns irq", 32'(d), 1);
    chk("R6 group clears sticky", 32'(raw_stat), 0);
    chk("R10 irq drops", 32'(irq_out), 0);
  endtask

  task automatic t_abort();
    logic [15:0] d;
    hold_cond = 1'b1;
    abort_valid = 1'b1; abort_cause = 16'h0205; step();
    abort_valid = 1'b0; abort_cause = '0;
    chk("R4 abort raw", 32'(raw_stat), 32'h40);
    chk("R12 cause captured", 32'(abrt_src), 32'h0205);
    chk("R11 flush high", 32'(flush_hold), 1);
    step(); step();
    chk("R11 flush persists", 32'(flush_hold), 1);
    do_read(8'h54, d);
    chk("R7 rd abort flag", 32'(d), 1);
    chk("R7 raw6 cleared", 32'(raw_stat), 0);
    chk("R7 flush released", 32'(flush_hold), 0);
    chk("R8 bit9 held", 32'(abrt_src), 32'h0200);
    do_read(8'h40, d);
    chk("R8 bit9 held over group", 32'(abrt_src), 32'h0200);
    hold_cond = 1'b0; step();
    do_read(8'h40, d);
    chk("R8 bit9 clears when cause gone", 32'(abrt_src), 0);
  endtask

  task automatic t_race();
    logic [15:0] d;
    ev_set = 8'h01; rd_en = 1'b1; rd_addr = 8'h44; step();
    ev_set = '0; rd_en = 1'b0;
    chk("R9 set beats clear", 32'(raw_stat), 1);
    do_read(8'h44, d);
    chk("R9 later clear works", 32'(raw_stat), 0);
    abort_valid = 1'b1; abort_cause = 16'h0001; rd_en = 1'b1; rd_addr = 8'h54; step();
    abort_valid = 1'b0; abort_cause = '0; rd_en = 1'b0;
    chk("R9 abort beats clear raw", 32'(raw_stat), 32'h40);
    chk("R9 abort beats clear flush", 32'(flush_hold), 1);
    chk("R9 abort beats clear src", 32'(abrt_src), 1);
    do_read(8'h54, d);
    chk("R9 flush then released", 32'(flush_hold), 0);
    chk("R7 src cleared", 32'(abrt_src), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    t_reset();
    t_levels();
    t_single_clears();
    t_unmapped();
    t_mask_group();
    t_abort();
    t_race();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end
endmodule